// File: doc/BRIEF.md
# High/Low-Time Clock Divider

This block divides a source clock by a programmable ratio. The ratio is the sum of two 6-bit phase counts. One count sets how many source cycles the divided clock stays high, and the other sets how many cycles it stays low. An edge-shift flag moves the falling edge of the output half a source cycle later, so an odd ratio can reach a duty cycle close to 50%. A bypass flag sends the source clock straight to the output, which gives a ratio of one.

Every output period starts with a rising edge. The block also raises a pulse, one source cycle wide, in the first source cycle of each output period. A new configuration word is sampled only at a period boundary. Changing the word in the middle of a period therefore never shortens or stretches the period that is already running.

The reset input is asserted asynchronously and released in step with the source clock. While reset is asserted, the output clock and the pulse are both low.

Top module: `hl_clk_div`

## Requirements
- R1: The configuration word is decoded as follows: low-time count in bits 5:0, high-time count in bits 11:6, edge-shift flag in bit 12, bypass flag in bit 13.
- R2: With bypass and edge-shift clear, each output period begins with a rising edge. The output is then high for the high-time count and low for the low-time count, both measured in source cycles, so the period equals their sum.
- R3: With edge-shift set and bypass clear, the high time is the high-time count plus half a source cycle, the low time is the low-time count minus half a source cycle, and the period is unchanged.
- R4: With bypass set, the output follows the source clock whatever the count fields hold, and the pulse stays high in every source cycle.
- R5: When bypass is clear, a count field of zero acts as a count of one.
- R6: A ratio N encoded by the rule gives a period of N source cycles, and the high and low times differ by at most one half source cycle. For even N the rule is low = high = N/2 with edge-shift clear. For odd N it is low = (N+1)/2, high = (N-1)/2 with edge-shift set. For N = 1 it is bypass set.
- R7: A configuration is taken only at a period boundary. A change made during a period leaves that period intact. A change that is present in the source cycle before a boundary governs the period that starts at that boundary.
- R8: When bypass is clear, the pulse is high for exactly one source cycle per output period, namely the first cycle of the high phase.
- R9: While reset is asserted, the output clock and the pulse are low, and reset acts without waiting for a clock edge. The first period after release uses the configuration present at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assertion |
| cfg_i | input | 14 | Configuration word: low count, high count, edge-shift, bypass |
| clk_div_o | output | 1 | Divided output clock |
| pulse_o | output | 1 | One-cycle pulse at the start of each output period |

## Verification
Two events can land in the same source cycle: a new configuration word arriving, and the boundary at which the sequencer reloads. The bench provokes this by changing the word on the falling source edge half a cycle before a boundary, then again in the middle of a high phase. In both cases it measures the high and low times of the outgoing period and of the following period. The old period must keep its full length, and the new ratio must take effect exactly at the next rising edge of the output.

// File: rtl/hl_div_pkg.sv
package hl_div_pkg;

  // Phase of the divided clock as seen by the sequencer
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Mode flags carried from decoder to sequencer
  typedef struct packed {
    logic byp;
    logic edge_on;
  } div_mode_t;

endpackage

// File: rtl/hl_rst_sync.sv
module hl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/hl_cfg_decode.sv
module hl_cfg_decode
  import hl_div_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic [2*CNT_W+1:0] cfg_i,
  output logic [CNT_W-1:0]   hi_o,
  output logic [CNT_W-1:0]   lo_o,
  output div_mode_t          mode_o
);

  localparam int unsigned NFIELD   = 2;
  localparam int unsigned EDGE_POS = 2 * CNT_W;
  localparam int unsigned BYP_POS  = 2 * CNT_W + 1;

  logic [CNT_W-1:0] raw_f [NFIELD];
  logic [CNT_W-1:0] eff_f [NFIELD];

  // field 0 = low time, field 1 = high time
  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    assign raw_f[f] = cfg_i[f*CNT_W +: CNT_W];
    always_comb begin
      if (raw_f[f] == '0) begin
        eff_f[f] = CNT_W'(1);
      end else begin
        eff_f[f] = raw_f[f];
      end
    end
  end

  assign lo_o           = eff_f[0];
  assign hi_o           = eff_f[1];
  assign mode_o.edge_on = cfg_i[EDGE_POS];
  assign mode_o.byp     = cfg_i[BYP_POS];

endmodule

// File: rtl/hl_phase_seq.sv
module hl_phase_seq
  import hl_div_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] nxt_hi_i,
  input  logic [CNT_W-1:0] nxt_lo_i,
  input  div_mode_t        nxt_mode_i,
  output logic             phase_hi_o,
  output logic             pulse_o,
  output logic             byp_o,
  output logic             edge_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_hi_o,
  output logic [CNT_W-1:0] act_lo_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] act_hi_q, act_lo_q;
  div_mode_t        mode_q;
  logic             hi_last, lo_last, load_en;

  // next-state logic
  always_comb begin
    hi_last = (phase_q == PH_HIGH) && (cnt_q == ONE);
    lo_last = (phase_q == PH_LOW) && (cnt_q == ONE);
    load_en = mode_q.byp | lo_last;
    phase_d = phase_q;
    cnt_d   = cnt_q - ONE;
    first_d = 1'b0;
    if (load_en) begin
      phase_d = PH_HIGH;
      cnt_d   = nxt_hi_i;
      first_d = 1'b1;
    end else if (hi_last) begin
      phase_d = PH_LOW;
      cnt_d   = act_lo_q;
    end
  end

  // sequencer state: reset parks at the last low cycle so the first edge loads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      cnt_q   <= ONE;
      first_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  // active configuration, enabled only at a boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_hi_q <= ONE;
      act_lo_q <= ONE;
      mode_q   <= '0;
    end else if (load_en) begin
      act_hi_q <= nxt_hi_i;
      act_lo_q <= nxt_lo_i;
      mode_q   <= nxt_mode_i;
    end
  end

  assign phase_hi_o = (phase_q == PH_HIGH);
  assign pulse_o    = first_q;
  assign byp_o      = mode_q.byp;
  assign edge_o     = mode_q.edge_on;
  assign cnt_o      = cnt_q;
  assign act_hi_o   = act_hi_q;
  assign act_lo_o   = act_lo_q;

endmodule

// File: rtl/hl_out_stage.sv
module hl_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_i,
  input  logic edge_i,
  input  logic byp_i,
  output logic clk_o
);

  logic neg_q;
  logic shaped;

  // half-cycle delayed copy of the divided phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q <= 1'b0;
    end else begin
      neg_q <= div_i;
    end
  end

  always_comb begin
    shaped = div_i | (edge_i & neg_q);
    clk_o  = byp_i ? clk_i : shaped;
  end

endmodule

// File: rtl/hl_clk_div.sv
module hl_clk_div
  import hl_div_pkg::*;
#(
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk_src_i,
  input  logic               rst_ni,
  input  logic [2*CNT_W+1:0] cfg_i,
  output logic               clk_div_o,
  output logic               pulse_o
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] nxt_hi, nxt_lo;
  div_mode_t        nxt_mode;
  logic             phase_hi, byp_act, edge_act;
  logic [CNT_W-1:0] cnt_cur, act_hi, act_lo;

  hl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_src_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  hl_cfg_decode #(.CNT_W(CNT_W)) u_dec (
    .cfg_i  (cfg_i),
    .hi_o   (nxt_hi),
    .lo_o   (nxt_lo),
    .mode_o (nxt_mode)
  );

  hl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_src_i),
    .rst_ni     (rst_sync_n),
    .nxt_hi_i   (nxt_hi),
    .nxt_lo_i   (nxt_lo),
    .nxt_mode_i (nxt_mode),
    .phase_hi_o (phase_hi),
    .pulse_o    (pulse_o),
    .byp_o      (byp_act),
    .edge_o     (edge_act),
    .cnt_o      (cnt_cur),
    .act_hi_o   (act_hi),
    .act_lo_o   (act_lo)
  );

  hl_out_stage u_out (
    .clk_i  (clk_src_i),
    .rst_ni (rst_sync_n),
    .div_i  (phase_hi),
    .edge_i (edge_act),
    .byp_i  (byp_act),
    .clk_o  (clk_div_o)
  );

endmodule

// File: rtl/hl_clk_div_chk.sv
module hl_clk_div_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pulse_i,
  input logic             phase_hi_i,
  input logic             byp_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] act_hi_i,
  input logic [CNT_W-1:0] act_lo_i
);

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !byp_i) |=> !pulse_i); // R8

  AST_PULSE_OPENS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> phase_hi_i); // R8

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |-> ($stable(act_hi_i) && $stable(act_lo_i) && $stable(byp_i))); // R7

  AST_BYPASS_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_i |-> pulse_i); // R4

  AST_HIGH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_hi_i && !byp_i) |-> (cnt_i != '0 && cnt_i <= act_hi_i)); // R2

  AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_hi_i |-> (cnt_i != '0 && cnt_i <= act_lo_i)); // R2

  AST_NO_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_hi_i != '0) && (act_lo_i != '0)); // R5

endmodule

bind hl_clk_div hl_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_src_i),
  .rst_ni     (rst_sync_n),
  .pulse_i    (pulse_o),
  .phase_hi_i (phase_hi),
  .byp_i      (byp_act),
  .cnt_i      (cnt_cur),
  .act_hi_i   (act_hi),
  .act_lo_i   (act_lo)
);

// File: tb/hl_clk_div_test.sv
`timescale 1ns/1ps
module hl_clk_div_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] cfg = '0;
  logic        clk_div;
  logic        pulse;
  int          n_run = 0;
  int          n_fail = 0;
  int          neg_cnt = 0;
  int          pul_cnt = 0;

  always #10 clk = ~clk;

  hl_clk_div uut (
    .clk_src_i (clk),
    .rst_ni    (rst_n),
    .cfg_i     (cfg),
    .clk_div_o (clk_div),
    .pulse_o   (pulse)
  );

  always @(negedge clk) begin
    neg_cnt++;
    if (pulse) pul_cnt++;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // bit 13 bypass, bit 12 edge, 11:6 high, 5:0 low
  function automatic logic [13:0] mk(input int hi, input int lo, input bit ed, input bit by);
    return {by, ed, 6'(hi), 6'(lo)};
  endfunction

  function automatic logic [13:0] enc(input int n);
    return mk(n / 2, (n + 1) / 2, 1'(n % 2), n == 1);
  endfunction

  function automatic int exp_high(input logic [13:0] c);
    if (c[13]) return 1;
    return 2 * eff(int'(c[11:6])) + int'(c[12]);
  endfunction

  function automatic int exp_low(input logic [13:0] c);
    if (c[13]) return 1;
    return 2 * eff(int'(c[5:0])) - int'(c[12]);
  endfunction

  function automatic int exp_ratio(input logic [13:0] c);
    if (c[13]) return 1;
    return eff(int'(c[11:6])) + eff(int'(c[5:0]));
  endfunction

  // one output period: high/low in half source cycles, pulses, source cycles
  task automatic measure(output int hh, output int ll, output int pp, output int np);
    realtime tr, tf, tr2;
    int p0, n0;
    @(posedge clk_div); tr = $realtime; p0 = pul_cnt; n0 = neg_cnt;
    @(negedge clk_div); tf = $realtime;
    @(posedge clk_div); tr2 = $realtime;
    hh = int'((tf - tr) / 10.0);
    ll = int'((tr2 - tf) / 10.0);
    pp = pul_cnt - p0;
    np = neg_cnt - n0;
  endtask

  task automatic check_period(input string tag, input logic [13:0] c);
    int hh, ll, pp, np;
    measure(hh, ll, pp, np);
    chk(tag, "high half-cycles", hh, exp_high(c));
    chk(tag, "low half-cycles", ll, exp_low(c));
    chk(tag, "period cycles", np, exp_ratio(c));
    chk("R8", "pulses per period", pp, 1);
  endtask

  task automatic run_cfg(input string tag, input logic [13:0] c);
    @(negedge clk);
    cfg = c;
    @(posedge clk_div);
    check_period(tag, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R8 watchdog: actual 150000 cycles expected fewer");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cfg = enc(4);
    repeat (3) @(negedge clk);
    chk("R9", "clk_div in reset", int'(clk_div), 0);
    chk("R9", "pulse in reset", int'(pulse), 0);
    rst_n = 1'b1;
    check_period("R9", enc(4));

    // encoding rule, ratios 1..12
    for (int n = 1; n <= 12; n++) begin
      int hh, ll;
      run_cfg("R6", enc(n));
      hh = exp_high(enc(n));
      ll = exp_low(enc(n));
      chk("R6", "duty spread", (hh > ll) ? hh - ll : ll - hh, (n % 2 == 1 && n > 1) ? 0 : 0);
    end

    // field positions and plain counts
    run_cfg("R1", mk(7, 2, 1'b0, 1'b0));
    run_cfg("R2", mk(2, 9, 1'b0, 1'b0));
    run_cfg("R3", mk(4, 2, 1'b1, 1'b0));
    run_cfg("R3", mk(1, 1, 1'b1, 1'b0));
    run_cfg("R5", mk(0, 0, 1'b0, 1'b0));
    run_cfg("R5", mk(0, 5, 1'b1, 1'b0));
    run_cfg("R4", mk(37, 11, 1'b1, 1'b1));
    run_cfg("R4", mk(63, 63, 1'b0, 1'b1));

    // change half a cycle before a boundary
    begin
      realtime tf, tr;
      int hh, ll, pp, np;
      run_cfg("R2", enc(12));
      @(posedge clk_div);
      @(negedge clk_div); tf = $realtime;
      repeat (5) @(posedge clk);
      @(negedge clk);
      cfg = enc(5);
      @(posedge clk_div); tr = $realtime;
      chk("R7", "old low before late change", int'((tr - tf) / 10.0), 12);
      @(negedge clk_div);
      chk("R7", "new high after late change", int'(($realtime - tr) / 10.0), exp_high(enc(5)));
      measure(hh, ll, pp, np);
      chk("R7", "new period after late change", np, 5);
    end

    // change in the middle of a high phase
    begin
      realtime tr, tf, tr2;
      run_cfg("R2", enc(12));
      @(posedge clk_div); tr = $realtime;
      repeat (2) @(negedge clk);
      cfg = enc(3);
      @(negedge clk_div); tf = $realtime;
      @(posedge clk_div); tr2 = $realtime;
      chk("R7", "high kept after mid change", int'((tf - tr) / 10.0), 12);
      chk("R7", "low kept after mid change", int'((tr2 - tf) / 10.0), 12);
      @(negedge clk_div);
      chk("R7", "new high after mid change", int'(($realtime - tr2) / 10.0), 3);
    end

    // asynchronous reset in the middle of a high phase
    run_cfg("R2", enc(8));
    @(posedge clk_div);
    #15;
    rst_n = 1'b0;
    #2;
    chk("R9", "clk_div after async reset", int'(clk_div), 0);
    chk("R9", "pulse after async reset", int'(pulse), 0);
    @(negedge clk);
    cfg = enc(6);
    rst_n = 1'b1;
    check_period("R9", enc(6));

    // random configurations
    for (int i = 0; i < 24; i++) begin
      logic [13:0] c;
      c = mk(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
             1'($urandom_range(0, 1)), $urandom_range(0, 7) == 0);
      if (c[13]) run_cfg("R4", c);
      else if (c[12]) run_cfg("R3", c);
      else run_cfg("R2", c);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule